// File: doc/BRIEF.md
# Inbound Descriptor-Chain DMA Channel

This block is one receive channel of a DMA engine. A client hands it a byte stream over a valid/ready handshake, with a flag marking the last byte of each packet. The channel stores those bytes into memory buffers. Each buffer is described by a descriptor held in memory, and each descriptor points to the next, so one start command can fill a whole chain of buffers.

Every descriptor is four 32-bit words at ascending byte addresses:

| Offset | Contents |
|--------|----------|
| +0 | next-descriptor pointer |
| +4 | buffer start |
| +8 | buffer end, exclusive |
| +12 | flags |

The flags word uses three bits. Bit 0 ends the list. Bit 1 requests an interrupt on completion. Bit 4 is set by the channel when a packet ended inside that buffer.

A descriptor finishes when its buffer fills or its packet ends. The channel then writes back the true end address and the flags, and either follows the chain or stops at the end of the list. Completion events are collected in a raw cause register. That register is masked and acknowledged by software and drives a single interrupt line.

Software uses a small word-indexed register file:

| Index | Register | Access |
|-------|----------|--------|
| 0 | enable, bit 0 | read/write |
| 1 | start command, bit 0 | write |
| 2 | descriptor pointer | read/write, written only while idle |
| 3 | write position | read-only |
| 4 | context-word address | read/write |
| 5 | interrupt mask | read/write |
| 6 | acknowledge | write, reads 0 |
| 7 | raw causes | read-only |
| 8 | masked causes | read-only |
| 9 | status: bit 0 active, bit 1 end-of-list reached | read-only |

Memory is a single port with byte enables. Read data returns one cycle after the request.

Top module: `desc_rx_dma`

## Requirements
- R1: After reset, in_ready and irq are low, and the raw cause and status registers read 0.
- R2: A start command (index 1, bit 0) given while enabled reads the four descriptor words at the descriptor pointer and then raises in_ready, with the write position set to the buffer start. A start command given while disabled is ignored.
- R3: Each accepted byte is written in the same cycle to the word holding the write position. mem_be has the single bit given by address bits [1:0] set, the byte is replicated on all four lanes, and the write position then advances by one.
- R4: When the write position reaches the buffer end, the descriptor completes. Word +8 is rewritten with the end address, and word +12 is rewritten with bit 4 clear.
- R5: A byte carrying in_eop completes the descriptor early. Word +8 becomes the address after that byte, word +12 gets bit 4 set, and raw cause bit 3 is set.
- R6: A completing descriptor with flag bit 1 set sets raw cause bits 0 and 1. Raw bits rise only on a completion.
- R7: After write-back of a descriptor with flag bit 0 set, the value 1 is written to the context-word address. Status bit 1 is then set and input is refused.
- R8: Without flag bit 0, the next descriptor is fetched and the rest of the packet continues at its buffer start with no byte lost.
- R9: in_ready is low while descriptor words are being read or written back.
- R10: Writing the acknowledge register clears the raw bits set in the written value, and the acknowledge register reads 0.
- R11: The masked register equals raw AND mask, and irq is high exactly when it is nonzero.
- R12: Clearing the enable bit returns the channel to idle at once, with in_ready low and status bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 4 | register index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational on reg_addr |
| in_valid | input | 1 | input byte valid |
| in_data | input | 8 | input byte |
| in_eop | input | 1 | byte is last of packet |
| in_ready | output | 1 | channel accepts a byte |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | access is a write |
| mem_addr | output | ADDR_W | byte address (word-aligned for word accesses) |
| mem_be | output | 4 | byte enables for writes |
| mem_wdata | output | 32 | write data |
| mem_rdata | input | 32 | read data, valid the cycle after a read request |
| irq | output | 1 | interrupt line |

## Verification
A register write takes effect at the clock edge that samples it. After a start command, in_ready rises five edges later: four read requests, then one edge to capture the flags word. A byte's memory write happens at its acceptance edge. The raw cause bits show the completion on the next cycle. The two write-back words follow on the next two edges, and then either the context write or the next descriptor fetch. The bench drives on falling edges, waits for in_ready with a bounded poll, and checks memory and registers only after a fixed margin of four cycles past the last accepted byte. The in_ready check for R9 is sampled on the falling edge right after a completing byte, when the first write-back is under way.

// File: rtl/desc_rx_pkg.sv
package desc_rx_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_LANES = WORD_W / 8;
  localparam int REG_IDX_W  = 4;
  localparam int CAUSE_W    = 4;
  localparam int DESC_WORDS = 4;

  // register indices
  localparam logic [REG_IDX_W-1:0] RI_ENABLE = 4'd0;
  localparam logic [REG_IDX_W-1:0] RI_START  = 4'd1;
  localparam logic [REG_IDX_W-1:0] RI_DESC   = 4'd2;
  localparam logic [REG_IDX_W-1:0] RI_WPOS   = 4'd3;
  localparam logic [REG_IDX_W-1:0] RI_CTX    = 4'd4;
  localparam logic [REG_IDX_W-1:0] RI_MASK   = 4'd5;
  localparam logic [REG_IDX_W-1:0] RI_ACK    = 4'd6;
  localparam logic [REG_IDX_W-1:0] RI_RAW    = 4'd7;
  localparam logic [REG_IDX_W-1:0] RI_MASKED = 4'd8;
  localparam logic [REG_IDX_W-1:0] RI_STATUS = 4'd9;

  // descriptor word slots
  localparam int DW_NEXT  = 0;
  localparam int DW_BUF   = 1;
  localparam int DW_END   = 2;
  localparam int DW_FLAGS = 3;

  // flag bit positions
  localparam int FB_LAST  = 0;
  localparam int FB_INTR  = 1;
  localparam int FB_INEOP = 4;

  // cause bit positions
  localparam int CB_DONE0 = 0;
  localparam int CB_DONE1 = 1;
  localparam int CB_EOP   = 3;

  localparam logic [WORD_W-1:0] CTX_OFF_MARK = 32'h0000_0001;

  typedef enum logic [2:0] {
    ES_IDLE,
    ES_FETCH,
    ES_RUN,
    ES_WB_END,
    ES_WB_FLAGS,
    ES_CTX
  } eng_state_e;
endpackage

// File: rtl/desc_rx_rst_sync.sv
module desc_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/desc_rx_regs.sv
module desc_rx_regs
  import desc_rx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  input  logic [CAUSE_W-1:0]   set_cause,
  input  logic [ADDR_W-1:0]    eng_wpos,
  input  logic [ADDR_W-1:0]    eng_desc,
  input  logic                 eng_active,
  input  logic                 eng_last,
  output logic                 cfg_en,
  output logic                 start_cmd,
  output logic                 desc_wr,
  output logic [ADDR_W-1:0]    ctx_ptr,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [CAUSE_W-1:0]   raw_q,
  output logic [WORD_W-1:0]    mask_q,
  output logic                 irq
);
  logic                en_q, en_d;
  logic [ADDR_W-1:0]   ctx_q, ctx_d;
  logic [CAUSE_W-1:0]  raw_d;
  logic [WORD_W-1:0]   mask_d;
  logic [CAUSE_W-1:0]  ack_bits;
  logic [WORD_W-1:0]   masked;

  assign ack_bits  = (reg_wr && reg_addr == RI_ACK) ? reg_wdata[CAUSE_W-1:0] : '0;
  assign start_cmd = reg_wr && reg_addr == RI_START && reg_wdata[0];
  assign desc_wr   = reg_wr && reg_addr == RI_DESC;

  always_comb begin
    en_d   = en_q;
    ctx_d  = ctx_q;
    mask_d = mask_q;
    if (reg_wr && reg_addr == RI_ENABLE) en_d   = reg_wdata[0];
    if (reg_wr && reg_addr == RI_CTX)    ctx_d  = reg_wdata[ADDR_W-1:0];
    if (reg_wr && reg_addr == RI_MASK)   mask_d = reg_wdata;
    // a new cause in the same cycle as its acknowledge survives
    raw_d = (raw_q & ~ack_bits) | set_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ctx_q  <= '0;
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      en_q   <= en_d;
      ctx_q  <= ctx_d;
      mask_q <= mask_d;
      raw_q  <= raw_d;
    end
  end

  assign masked  = WORD_W'(raw_q) & mask_q;
  assign irq     = |masked;
  assign cfg_en  = en_q;
  assign ctx_ptr = ctx_q;

  always_comb begin
    case (reg_addr)
      RI_ENABLE: reg_rdata = WORD_W'(en_q);
      RI_DESC:   reg_rdata = WORD_W'(eng_desc);
      RI_WPOS:   reg_rdata = WORD_W'(eng_wpos);
      RI_CTX:    reg_rdata = WORD_W'(ctx_q);
      RI_MASK:   reg_rdata = mask_q;
      RI_RAW:    reg_rdata = WORD_W'(raw_q);
      RI_MASKED: reg_rdata = masked;
      RI_STATUS: reg_rdata = WORD_W'({eng_last, eng_active});
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/desc_rx_engine.sv
module desc_rx_engine
  import desc_rx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  start_cmd,
  input  logic                  desc_wr,
  input  logic [ADDR_W-1:0]     desc_wdata,
  input  logic [ADDR_W-1:0]     ctx_ptr,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  input  logic                  in_eop,
  output logic                  in_ready,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [BYTE_LANES-1:0] mem_be,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic [CAUSE_W-1:0]    set_cause,
  output logic [ADDR_W-1:0]     wpos,
  output logic [ADDR_W-1:0]     desc_ptr,
  output logic                  active,
  output logic                  last_hit
);
  localparam int PTR_SLOTS = DESC_WORDS - 1;
  localparam int CNT_W     = $clog2(DESC_WORDS + 1);
  localparam logic [ADDR_W-1:0] PTR_ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_END   = ADDR_W'(4 * DW_END);
  localparam logic [ADDR_W-1:0] OFS_FLAGS = ADDR_W'(4 * DW_FLAGS);
  localparam logic [CNT_W-1:0]  CNT_DONE  = CNT_W'(DESC_WORDS);

  eng_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] wpos_q, wpos_d;
  logic [ADDR_W-1:0] desc_q, desc_d;
  logic              eop_q, eop_d;
  logic              last_q, last_d;
  logic [DESC_WORDS-1:0]            cap_en;
  logic [PTR_SLOTS-1:0][ADDR_W-1:0] ptr_w;
  logic [WORD_W-1:0] flags_q;
  logic [ADDR_W-1:0] wpos_inc;
  logic              room;

  // descriptor word capture: slot k arrives one cycle after read k
  for (genvar k = 0; k < DESC_WORDS; k++) begin : g_cap
    assign cap_en[k] = (st_q == ES_FETCH) && (cnt_q == CNT_W'(k + 1));
  end

  for (genvar k = 0; k < PTR_SLOTS; k++) begin : g_slot
    logic [ADDR_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         slot_q <= '0;
      else if (cap_en[k]) slot_q <= mem_rdata[ADDR_W-1:0];
    end
    assign ptr_w[k] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flags_q <= '0;
    else if (cap_en[DW_FLAGS]) flags_q <= mem_rdata;
  end

  assign wpos_inc = wpos_q + PTR_ONE;
  assign room     = (wpos_q != ptr_w[DW_END]);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    wpos_d    = wpos_q;
    desc_d    = desc_q;
    eop_d     = eop_q;
    last_d    = last_q;
    in_ready  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    set_cause = '0;
    if (!cfg_en) begin
      st_d = ES_IDLE;
      cnt_d = '0;
      if (desc_wr && st_q == ES_IDLE) desc_d = desc_wdata;
    end else begin
      case (st_q)
        ES_IDLE: begin
          if (desc_wr) desc_d = desc_wdata;
          if (start_cmd) begin
            last_d = 1'b0;
            cnt_d  = '0;
            st_d   = ES_FETCH;
          end
        end
        ES_FETCH: begin
          if (cnt_q != CNT_DONE) begin
            mem_req  = 1'b1;
            mem_addr = desc_q + ADDR_W'({cnt_q[1:0], 2'b00});
            cnt_d    = cnt_q + CNT_W'(1);
          end else begin
            wpos_d = ptr_w[DW_BUF];
            cnt_d  = '0;
            st_d   = ES_RUN;
          end
        end
        ES_RUN: begin
          in_ready = room;
          if (in_valid && room) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {wpos_q[ADDR_W-1:2], 2'b00};
            mem_be    = BYTE_LANES'(1) << wpos_q[1:0];
            mem_wdata = {BYTE_LANES{in_data}};
            wpos_d    = wpos_inc;
            if (wpos_inc == ptr_w[DW_END] || in_eop) begin
              eop_d = in_eop;
              if (flags_q[FB_INTR]) begin
                set_cause[CB_DONE0] = 1'b1;
                set_cause[CB_DONE1] = 1'b1;
              end
              set_cause[CB_EOP] = in_eop;
              st_d = ES_WB_END;
            end
          end
        end
        ES_WB_END: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = desc_q + OFS_END;
          mem_be    = '1;
          mem_wdata = WORD_W'(wpos_q);
          st_d      = ES_WB_FLAGS;
        end
        ES_WB_FLAGS: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = desc_q + OFS_FLAGS;
          mem_be    = '1;
          mem_wdata = flags_q | (WORD_W'(eop_q) << FB_INEOP);
          if (flags_q[FB_LAST]) begin
            st_d = ES_CTX;
          end else begin
            desc_d = ptr_w[DW_NEXT];
            cnt_d  = '0;
            st_d   = ES_FETCH;
          end
        end
        ES_CTX: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = ctx_ptr;
          mem_be    = '1;
          mem_wdata = CTX_OFF_MARK;
          last_d    = 1'b1;
          st_d      = ES_IDLE;
        end
        default: st_d = ES_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ES_IDLE;
      cnt_q  <= '0;
      wpos_q <= '0;
      desc_q <= '0;
      eop_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wpos_q <= wpos_d;
      desc_q <= desc_d;
      eop_q  <= eop_d;
      last_q <= last_d;
    end
  end

  assign wpos     = wpos_q;
  assign desc_ptr = desc_q;
  assign active   = (st_q != ES_IDLE);
  assign last_hit = last_q;
endmodule

// File: rtl/desc_rx_dma.sv
module desc_rx_dma
  import desc_rx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  input  logic                 in_eop,
  output logic                 in_ready,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [3:0]           mem_be,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 irq
);
  logic                rst_core_n;
  logic                cfg_en;
  logic                start_cmd;
  logic                desc_wr;
  logic [ADDR_W-1:0]   ctx_ptr;
  logic [CAUSE_W-1:0]  set_cause;
  logic [CAUSE_W-1:0]  raw_vec;
  logic [WORD_W-1:0]   mask_vec;
  logic [ADDR_W-1:0]   wpos;
  logic [ADDR_W-1:0]   desc_ptr;
  logic                eng_active;
  logic                eng_last;

  desc_rx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  desc_rx_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .set_cause  (set_cause),
    .eng_wpos   (wpos),
    .eng_desc   (desc_ptr),
    .eng_active (eng_active),
    .eng_last   (eng_last),
    .cfg_en     (cfg_en),
    .start_cmd  (start_cmd),
    .desc_wr    (desc_wr),
    .ctx_ptr    (ctx_ptr),
    .reg_rdata  (reg_rdata),
    .raw_q      (raw_vec),
    .mask_q     (mask_vec),
    .irq        (irq)
  );

  desc_rx_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cfg_en     (cfg_en),
    .start_cmd  (start_cmd),
    .desc_wr    (desc_wr),
    .desc_wdata (reg_wdata[ADDR_W-1:0]),
    .ctx_ptr    (ctx_ptr),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_eop     (in_eop),
    .in_ready   (in_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .set_cause  (set_cause),
    .wpos       (wpos),
    .desc_ptr   (desc_ptr),
    .active     (eng_active),
    .last_hit   (eng_last)
  );
endmodule

// File: rtl/desc_rx_sva.sv
module desc_rx_sva
  import desc_rx_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [REG_IDX_W-1:0] reg_addr,
  input logic [WORD_W-1:0]    reg_wdata,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic [3:0]           mem_be,
  input logic                 irq,
  input logic                 cfg_en,
  input logic                 eng_last,
  input logic [CAUSE_W-1:0]   set_cause,
  input logic [CAUSE_W-1:0]   raw_vec,
  input logic [WORD_W-1:0]    mask_vec
);
  assert_fetch_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !in_ready);

  assert_single_lane_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (mem_req && mem_we && $countones(mem_be) == 1));

  assert_list_end_refuses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_last |-> !in_ready);

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RI_ACK && set_cause == '0)
      |=> ((raw_vec & $past(reg_wdata[CAUSE_W-1:0])) == '0));

  assert_raw_rises_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_vec & ~$past(raw_vec)) != '0) |-> ($past(set_cause) != '0));

  assert_no_mask_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == '0) |-> !irq);

  assert_disable_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !in_ready);
endmodule

bind desc_rx_dma desc_rx_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .irq       (irq),
  .cfg_en    (cfg_en),
  .eng_last  (eng_last),
  .set_cause (set_cause),
  .raw_vec   (raw_vec),
  .mask_vec  (mask_vec)
);

// File: tb/desc_rx_dma_tb_top.sv
module desc_rx_dma_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int WDOG       = 20000;

  logic              clk;
  logic              rst_n;
  logic              reg_wr;
  logic [3:0]        reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              in_valid;
  logic [7:0]        in_data;
  logic              in_eop;
  logic              in_ready;
  logic              mem_req;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata;
  logic              irq;

  logic              tb_we;
  logic [ADDR_W-1:0] tb_addr;
  logic [31:0]       tb_data;
  logic [31:0]       mem [0:255];

  int checks;
  int failures;
  bit done;

  desc_rx_dma #(.ADDR_W(ADDR_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_eop    (in_eop),
    .in_ready  (in_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (tb_we) begin
      mem[tb_addr[9:2]] <= tb_data;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = idx;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic put_desc(input logic [ADDR_W-1:0] at, input logic [31:0] nxt,
                          input logic [31:0] bstart, input logic [31:0] bend, input logic [31:0] fl);
    poke(at, nxt);
    poke(at + 16'd4, bstart);
    poke(at + 16'd8, bend);
    poke(at + 16'd12, fl);
  endtask

  task automatic send(input logic [7:0] d, input logic e, input string req);
    int n;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_eop = e;
    n = 0;
    while (!in_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) chk(req, "in_ready never rose", {31'b0, in_ready}, 32'h1);
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1", "in_ready", {31'b0, in_ready}, 32'h0);
    chk("R1", "irq", {31'b0, irq}, 32'h0);
    rd(4'd7, v); chk("R1", "raw", v, 32'h0);
    rd(4'd9, v); chk("R1", "status", v, 32'h0);
  endtask

  task automatic t_disabled_start;
    logic [31:0] v;
    put_desc(16'h0100, 32'h0, 32'h0200, 32'h0205, 32'h3);
    wr(4'd2, 32'h0100);
    wr(4'd1, 32'h1);
    repeat (8) @(negedge clk);
    chk("R2", "ready after start while disabled", {31'b0, in_ready}, 32'h0);
    rd(4'd9, v); chk("R2", "status after start while disabled", v, 32'h0);
  endtask

  task automatic t_full_buffer_last;
    logic [31:0] v;
    wr(4'd4, 32'h00F0);
    poke(16'h00F0, 32'h0);
    wr(4'd0, 32'h1);
    wr(4'd1, 32'h1);
    for (int i = 0; i < 5; i++) send(8'hA1 + 8'(i), 1'b0, "R3");
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++)
      chk("R3", "stored byte", {24'b0, mem_byte(16'h0200 + 16'(i))}, {24'b0, 8'hA1 + 8'(i)});
    chk("R4", "end word after full buffer", mem[16'h0108 >> 2], 32'h0205);
    chk("R4", "flags without eop", mem[16'h010C >> 2], 32'h3);
    chk("R7", "context mark", mem[16'h00F0 >> 2], 32'h1);
    rd(4'd9, v); chk("R7", "status end of list", v, 32'h2);
    chk("R7", "input refused", {31'b0, in_ready}, 32'h0);
    rd(4'd7, v); chk("R6", "raw after intr descriptor", v, 32'h3);
    rd(4'd3, v); chk("R3", "write position", v, 32'h0205);
    chk("R11", "irq masked off", {31'b0, irq}, 32'h0);
    wr(4'd5, 32'h2);
    rd(4'd8, v); chk("R11", "masked value", v, 32'h2);
    chk("R11", "irq raised", {31'b0, irq}, 32'h1);
    wr(4'd6, 32'h1);
    rd(4'd7, v); chk("R10", "raw after ack bit0", v, 32'h2);
    rd(4'd6, v); chk("R10", "ack reads zero", v, 32'h0);
    chk("R11", "irq still up", {31'b0, irq}, 32'h1);
    wr(4'd6, 32'h2);
    #1 chk("R11", "irq after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_chain_eop;
    logic [31:0] v;
    put_desc(16'h0140, 32'h0160, 32'h0301, 32'h0304, 32'h0);
    put_desc(16'h0160, 32'h0, 32'h0380, 32'h0390, 32'h1);
    wr(4'd4, 32'h00F4);
    poke(16'h00F4, 32'h0);
    wr(4'd2, 32'h0140);
    wr(4'd1, 32'h1);
    for (int i = 0; i < 5; i++) begin
      send(8'h51 + 8'(i), i == 4, "R8");
      if (i == 2) chk("R9", "ready during write-back", {31'b0, in_ready}, 32'h0);
    end
    repeat (4) @(negedge clk);
    chk("R8", "first buffer byte0", {24'b0, mem_byte(16'h0301)}, 32'h51);
    chk("R8", "first buffer byte2", {24'b0, mem_byte(16'h0303)}, 32'h53);
    chk("R8", "second buffer byte0", {24'b0, mem_byte(16'h0380)}, 32'h54);
    chk("R8", "second buffer byte1", {24'b0, mem_byte(16'h0381)}, 32'h55);
    chk("R4", "first end word", mem[16'h0148 >> 2], 32'h0304);
    chk("R4", "first flags", mem[16'h014C >> 2], 32'h0);
    chk("R5", "second end trimmed", mem[16'h0168 >> 2], 32'h0382);
    chk("R5", "second flags eop", mem[16'h016C >> 2], 32'h11);
    rd(4'd7, v); chk("R5", "raw eop only", v, 32'h8);
    chk("R7", "context mark", mem[16'h00F4 >> 2], 32'h1);
    rd(4'd3, v); chk("R5", "write position", v, 32'h0382);
    wr(4'd6, 32'hF);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    int n;
    put_desc(16'h0180, 32'h0, 32'h03A0, 32'h03B0, 32'h0);
    wr(4'd2, 32'h0180);
    wr(4'd1, 32'h1);
    n = 0;
    while (!in_ready && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk("R2", "ready after start", {31'b0, in_ready}, 32'h1);
    rd(4'd3, v); chk("R2", "write position at buffer start", v, 32'h03A0);
    rd(4'd9, v); chk("R2", "status active", v, 32'h1);
    wr(4'd0, 32'h0);
    chk("R12", "ready after disable", {31'b0, in_ready}, 32'h0);
    rd(4'd9, v); chk("R12", "status idle", v, 32'h0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_eop = 1'b0;
    tb_we = 1'b0; tb_addr = '0; tb_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_disabled_start;
    t_full_buffer_last;
    t_chain_eop;
    t_abort;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule